// File: doc/BRIEF.md
# Two-Group Lookup-Table Logic Fabric

This block is a small programmable logic fabric of sixteen cells, split into two groups of eight. Each cell evaluates any Boolean function of two inputs through a 4-bit truth-table code. Its result is either used straight away or taken from a cell flip-flop. A per-cell configuration word selects where the two inputs come from: a neighbour cell, a cell in the other group, the cell's own input pin, or one bit of a software data word.

Software reaches the fabric over a simple write/read-enable bus. The bus holds one configuration word per cell, a software data-in word, and a read-only snapshot of all cell outputs. The cell outputs also drive sixteen output pins. The last cell of group 0 drives an interrupt line, and the last cell of group 1 drives a trigger line.

Top module: `lutfab_array`

## Requirements
- R1: After a synchronous reset every configuration word, the data-in word, every cell flip-flop, `pin_out`, `irq_out`, `trig_out` and `bus_rdata` are zero.
- R2: Byte address 4*i reaches the configuration word of cell i, 0x40 reaches the 16-bit data-in word and 0x44 reaches the output snapshot. A word written with `bus_wr` is returned by a read. Bits [31:11] of a configuration word read as zero. Read data appears on `bus_rdata` one clock after `bus_rd`, and holds while no read is issued. Unmapped addresses read zero.
- R3: Configuration bits [4:1] hold a truth-table code T, and the cell's function value is T[2*A+B]. For example, 4'h8 gives AND, 4'h6 gives XOR, 4'hC gives A, 4'hA gives B and 4'hF gives constant 1.
- R4: With configuration bit 0 at 1, the cell output is the function value in the same cycle. With bit 0 at 0, the cell output is the function value registered at the previous clock edge.
- R5: Configuration bit 6 selects input A. At 1, A comes from routing mux 0. At 0, A comes from bit i of the data-in word.
- R6: Configuration bit 5 selects input B. At 1, B comes from `pin_in[i]`. At 0, B comes from routing mux 1.
- R7: Bits [10:9] select mux 0. For s = 1..3, mux 0 picks the cell s places earlier in the same group, wrapping within the group. For s = 0, cell 0 takes cell 15 and cell 8 takes cell 7. Every other cell takes the cell at the same position in the other group.
- R8: Bits [8:7] select mux 1. Selection n picks the cell at group base + 2n + (i mod 2).
- R9: Reading 0x44 returns the sixteen cell outputs as they were at the read edge, with cell i in bit i. Writes to 0x44 change nothing.
- R10: `pin_out[i]` is the output of cell i. `irq_out` follows cell 7 and `trig_out` follows cell 15.
- R11: A reset asserted mid-operation clears all configuration, data-in and flip-flop state at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pin_in | input | 16 | Dedicated input pin of each cell |
| pin_out | output | 16 | Output of each cell |
| irq_out | output | 1 | Output of the last cell of group 0 |
| trig_out | output | 1 | Output of the last cell of group 1 |

## Verification
A bypassed cell's output responds within the same cycle as the input or data-in change that feeds it. A registered cell shows its function value one edge later. A bus write takes effect at its clock edge, and read data arrives one edge after the read strobe. The bench changes inputs on the falling edge. At each rising edge it advances its own model: it registers function values, applies writes and forms read data. A quarter period after the edge it settles the model's combinational outputs and compares every output port, so each result is checked in the cycle it is due.

// File: rtl/lutfab_pkg.sv
package lutfab_pkg;

    // Per-cell configuration, MSB first: bits [10:9] .. bit 0
    typedef struct packed {
        logic [1:0] sel0;     // routing mux 0 select
        logic [1:0] sel1;     // routing mux 1 select
        logic       a_mux;    // 1: A from mux 0, 0: A from data-in bit
        logic       b_pin;    // 1: B from pin, 0: B from mux 1
        logic [3:0] code;     // truth table indexed by {A,B}
        logic       bypass;   // 1: unregistered output
    } elem_cfg_t;

    localparam int CFG_W   = $bits(elem_cfg_t);
    localparam int MUX_W   = 4;

    function automatic logic lut_pick(input logic [3:0] code,
                                      input logic a, input logic b);
        return code[{a, b}];
    endfunction

endpackage

// File: rtl/lutfab_element.sv
module lutfab_element
    import lutfab_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  elem_cfg_t        cfg,
    input  logic [MUX_W-1:0] m0_in,
    input  logic [MUX_W-1:0] m1_in,
    input  logic             pin,
    input  logic             din_bit,
    output logic             lut_o,
    output logic             out_o
);

    logic a_in;
    logic b_in;
    logic ff_q;

    always_comb begin
        a_in  = cfg.a_mux ? m0_in[cfg.sel0] : din_bit;
        b_in  = cfg.b_pin ? pin : m1_in[cfg.sel1];
        lut_o = lut_pick(cfg.code, a_in, b_in);
    end

    always_ff @(posedge clk) begin
        if (rst) ff_q <= 1'b0;
        else     ff_q <= lut_o;
    end

    always_comb out_o = cfg.bypass ? lut_o : ff_q;

endmodule

// File: rtl/lutfab_route.sv
module lutfab_route
    import lutfab_pkg::*;
#(
    parameter int GROUP_SIZE = 8,
    parameter int NUM_GROUPS = 2
) (
    input  logic [GROUP_SIZE*NUM_GROUPS-1:0]            elem_out,
    output logic [GROUP_SIZE*NUM_GROUPS-1:0][MUX_W-1:0] m0_src,
    output logic [GROUP_SIZE*NUM_GROUPS-1:0][MUX_W-1:0] m1_src
);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        for (genvar p = 0; p < GROUP_SIZE; p++) begin : g_pos
            localparam int IDX  = g*GROUP_SIZE + p;
            localparam int BASE = g*GROUP_SIZE;
            if (p == 0) begin : g_link
                // cross-link from the last cell of the preceding group
                assign m0_src[IDX][0] =
                    elem_out[((g+NUM_GROUPS-1)%NUM_GROUPS)*GROUP_SIZE + GROUP_SIZE-1];
            end else begin : g_peer
                assign m0_src[IDX][0] =
                    elem_out[((g+1)%NUM_GROUPS)*GROUP_SIZE + p];
            end
            for (genvar k = 1; k < MUX_W; k++) begin : g_prev
                assign m0_src[IDX][k] = elem_out[BASE + (p+GROUP_SIZE-k)%GROUP_SIZE];
            end
            for (genvar n = 0; n < MUX_W; n++) begin : g_pair
                assign m1_src[IDX][n] = elem_out[BASE + (2*n + IDX%2)%GROUP_SIZE];
            end
        end
    end

endmodule

// File: rtl/lutfab_regs.sv
module lutfab_regs
    import lutfab_pkg::*;
#(
    parameter int NUM_ELEM = 16,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    input  logic [NUM_ELEM-1:0] dout_vec,
    output elem_cfg_t           cfg_q [NUM_ELEM],
    output logic [NUM_ELEM-1:0] din_q,
    output logic [31:0]         bus_rdata
);

    localparam int IDX_W    = ADDR_W - 2;
    localparam int DIN_IDX  = NUM_ELEM;
    localparam int DOUT_IDX = NUM_ELEM + 1;

    logic [IDX_W-1:0] word_idx;
    logic [31:0]      rd_word;

    assign word_idx = bus_addr[ADDR_W-1:2];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_ELEM; i++) cfg_q[i] <= '0;
            din_q <= '0;
        end else if (bus_wr) begin
            for (int i = 0; i < NUM_ELEM; i++) begin
                if (int'(word_idx) == i) cfg_q[i] <= bus_wdata[CFG_W-1:0];
            end
            if (int'(word_idx) == DIN_IDX) din_q <= bus_wdata[NUM_ELEM-1:0];
        end
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_ELEM; i++) begin
            if (int'(word_idx) == i) rd_word = 32'(cfg_q[i]);
        end
        if (int'(word_idx) == DIN_IDX)  rd_word = 32'(din_q);
        if (int'(word_idx) == DOUT_IDX) rd_word = 32'(dout_vec);
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_word;
    end

endmodule

// File: rtl/lutfab_array.sv
module lutfab_array
    import lutfab_pkg::*;
#(
    parameter int GROUP_SIZE = 8,
    parameter int NUM_GROUPS = 2,
    parameter int ADDR_W     = 8
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               bus_wr,
    input  logic                               bus_rd,
    input  logic [ADDR_W-1:0]                  bus_addr,
    input  logic [31:0]                        bus_wdata,
    output logic [31:0]                        bus_rdata,
    input  logic [GROUP_SIZE*NUM_GROUPS-1:0]   pin_in,
    output logic [GROUP_SIZE*NUM_GROUPS-1:0]   pin_out,
    output logic                               irq_out,
    output logic                               trig_out
);

    localparam int NUM_ELEM = GROUP_SIZE * NUM_GROUPS;

    elem_cfg_t                       cfg_q [NUM_ELEM];
    logic [NUM_ELEM-1:0]             din_q;
    logic [NUM_ELEM-1:0]             elem_out;
    logic [NUM_ELEM-1:0]             lut_vec;
    logic [NUM_ELEM-1:0]             bypass_vec;
    logic [NUM_ELEM-1:0][MUX_W-1:0]  m0_src;
    logic [NUM_ELEM-1:0][MUX_W-1:0]  m1_src;

    lutfab_regs #(
        .NUM_ELEM (NUM_ELEM),
        .ADDR_W   (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .dout_vec  (elem_out),
        .cfg_q     (cfg_q),
        .din_q     (din_q),
        .bus_rdata (bus_rdata)
    );

    lutfab_route #(
        .GROUP_SIZE (GROUP_SIZE),
        .NUM_GROUPS (NUM_GROUPS)
    ) u_route (
        .elem_out (elem_out),
        .m0_src   (m0_src),
        .m1_src   (m1_src)
    );

    for (genvar i = 0; i < NUM_ELEM; i++) begin : g_elem
        lutfab_element u_elem (
            .clk     (clk),
            .rst     (rst),
            .cfg     (cfg_q[i]),
            .m0_in   (m0_src[i]),
            .m1_in   (m1_src[i]),
            .pin     (pin_in[i]),
            .din_bit (din_q[i]),
            .lut_o   (lut_vec[i]),
            .out_o   (elem_out[i])
        );
        assign bypass_vec[i] = cfg_q[i].bypass;
    end

    assign pin_out  = elem_out;
    assign irq_out  = elem_out[GROUP_SIZE-1];
    assign trig_out = elem_out[NUM_ELEM-1];

endmodule

// File: rtl/lutfab_array_chk.sv
module lutfab_array_chk
    import lutfab_pkg::*;
#(
    parameter int NUM_ELEM = 16,
    parameter int ADDR_W   = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_rd,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [31:0]         bus_rdata,
    input logic [NUM_ELEM-1:0] pin_out,
    input logic [NUM_ELEM-1:0] lut_vec,
    input logic [NUM_ELEM-1:0] bypass_vec
);

    // R2: reserved configuration bits read back as zero
    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && int'(bus_addr[ADDR_W-1:2]) < NUM_ELEM) |=> (bus_rdata[31:CFG_W] == '0));

    // R2: read data holds when no read is issued
    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

    // R9: snapshot read returns outputs seen at the read edge
    p_snapshot_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && int'(bus_addr[ADDR_W-1:2]) == NUM_ELEM+1) |=> (bus_rdata == 32'($past(pin_out))));

    // R11: reset leaves outputs and read data at zero
    p_reset_clear_r11: assert property (@(posedge clk)
        rst |=> (pin_out == '0 && bus_rdata == '0));

    // R4: registered cells present last cycle's function value
    for (genvar i = 0; i < NUM_ELEM; i++) begin : g_reg
        p_reg_path_r4: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !bypass_vec[i]) |-> (pin_out[i] == $past(lut_vec[i])));
    end

endmodule

bind lutfab_array lutfab_array_chk #(
    .NUM_ELEM (GROUP_SIZE*NUM_GROUPS),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .pin_out    (pin_out),
    .lut_vec    (lut_vec),
    .bypass_vec (bypass_vec)
);

// File: tb/lutfab_array_tb.sv
module lutfab_array_tb;

    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out;
    logic        irq_out;
    logic        trig_out;

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    // reference model state
    logic [10:0] m_cfg [16];
    logic [15:0] m_din = '0;
    logic [15:0] m_ff  = '0;
    logic [15:0] m_out = '0;
    logic [15:0] m_lut = '0;
    logic [31:0] m_rdata = '0;

    lutfab_array u_dut (
        .clk (clk), .rst (rst), .bus_wr (bus_wr), .bus_rd (bus_rd),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .pin_in (pin_in), .pin_out (pin_out), .irq_out (irq_out), .trig_out (trig_out)
    );

    always #(CLK_NS/2) clk = ~clk;

    function automatic logic [31:0] cfgw(int s0, int s1, int a, int b, int code, int byp);
        return 32'((s0 << 9) | (s1 << 7) | (a << 6) | (b << 5) | (code << 1) | byp);
    endfunction

    // settle combinational outputs by repeated passes (configurations are acyclic)
    task automatic model_eval();
        for (int pass = 0; pass < 17; pass++) begin
            for (int i = 0; i < 16; i++) begin
                int g = i / 8, p = i % 8, base = (i / 8) * 8;
                int s0 = m_cfg[i][10:9], s1 = m_cfg[i][8:7];
                logic m0, m1, a, b;
                if (s0 == 0) m0 = (p == 0) ? m_out[g == 0 ? 15 : 7] : m_out[((g + 1) % 2) * 8 + p];
                else         m0 = m_out[base + (p - s0 + 8) % 8];
                m1 = m_out[base + 2 * s1 + (i % 2)];
                a  = m_cfg[i][6] ? m0 : m_din[i];
                b  = m_cfg[i][5] ? pin_in[i] : m1;
                m_lut[i] = m_cfg[i][1 + 2 * a + b];
                m_out[i] = m_cfg[i][0] ? m_lut[i] : m_ff[i];
            end
        end
    endtask

    task automatic model_edge();
        int idx;
        model_eval();
        idx = bus_addr >> 2;
        if (rst) begin
            for (int i = 0; i < 16; i++) m_cfg[i] = '0;
            m_din = '0; m_ff = '0; m_rdata = '0;
        end else begin
            if (bus_rd) begin
                if (idx < 16)       m_rdata = 32'(m_cfg[idx]);
                else if (idx == 16) m_rdata = 32'(m_din);
                else if (idx == 17) m_rdata = 32'(m_out);
                else                m_rdata = '0;
            end
            m_ff = m_lut;
            if (bus_wr) begin
                if (idx < 16)       m_cfg[idx] = bus_wdata[10:0];
                else if (idx == 16) m_din = bus_wdata[15:0];
            end
        end
    endtask

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    initial for (int i = 0; i < 16; i++) m_cfg[i] = '0;

    always @(posedge clk) begin
        model_edge();
        #(CLK_NS/4);
        model_eval();
        check("pin_out",   32'(pin_out),  32'(m_out));
        check("irq_out",   32'(irq_out),  32'(m_out[7]));
        check("trig_out",  32'(trig_out), 32'(m_out[15]));
        check("bus_rdata", bus_rdata,     m_rdata);
    end

    task automatic bwrite(int a, logic [31:0] d);
        bus_wr = 1'b1; bus_addr = 8'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bread(int a);
        bus_rd = 1'b1; bus_addr = 8'(a);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic rnd_steps(int n);
        for (int k = 0; k < n; k++) begin
            pin_in = 16'($urandom);
            bwrite(16'h40, $urandom);
            bread(16'h44);
        end
    endtask

    task automatic background();
        for (int i = 0; i < 16; i++) bwrite(i * 4, cfgw(0, 0, 0, 0, 12, 0));
    endtask

    initial begin
        #(CLK_NS * 100000);
        n_bad++;
        $display("FAIL watchdog expired during %s", cur_req);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        cur_req = "R1";
        pin_in = 16'hFFFF;
        idle(3);

        cur_req = "R2";
        bwrite(12, 32'hFFFF_FFFF);
        bread(12);
        idle(2);
        bwrite(12, 32'h0);
        bwrite(16'h40, 32'h0000_A5A5);
        bread(16'h40);
        bread(16'h48);
        idle(1);

        background();

        cur_req = "R3";
        for (int code = 0; code < 16; code++) begin
            bwrite(0, cfgw(0, 0, 0, 1, code, 1));
            for (int ab = 0; ab < 4; ab++) begin
                pin_in[0] = ab[0];
                bwrite(16'h40, 32'(ab[1]));
            end
        end

        cur_req = "R4";
        bwrite(0, cfgw(0, 0, 0, 1, 6, 0));
        rnd_steps(8);

        cur_req = "R5";
        for (int a = 0; a < 2; a++) begin
            bwrite(20, cfgw(1, 0, a, 0, 12, 1));
            rnd_steps(6);
        end
        bwrite(20, cfgw(0, 0, 0, 0, 12, 0));

        cur_req = "R6";
        for (int b = 0; b < 2; b++) begin
            bwrite(20, cfgw(0, 1, 0, b, 10, 1));
            rnd_steps(6);
        end
        bwrite(20, cfgw(0, 0, 0, 0, 12, 0));

        cur_req = "R7";
        for (int t = 0; t < 4; t++) begin
            int el = (t == 0) ? 0 : (t == 1) ? 8 : (t == 2) ? 3 : 12;
            for (int s = 0; s < 4; s++) begin
                bwrite(el * 4, cfgw(s, 0, 1, 0, 12, 1));
                rnd_steps(3);
            end
            bwrite(el * 4, cfgw(0, 0, 0, 0, 12, 0));
        end

        cur_req = "R8";
        for (int el = 12; el < 14; el++) begin
            for (int s = 0; s < 4; s++) begin
                if (s != 2) begin
                    bwrite(el * 4, cfgw(0, s, 0, 0, 10, 1));
                    rnd_steps(3);
                end
            end
            bwrite(el * 4, cfgw(0, 0, 0, 0, 12, 0));
        end

        cur_req = "R9";
        bwrite(16'h40, 32'h0000_3C5A);
        idle(1);
        bwrite(16'h44, 32'hFFFF_FFFF);
        bread(16'h44);
        bread(16'h40);
        rnd_steps(4);

        cur_req = "R10";
        bwrite(28, cfgw(0, 0, 0, 0, 15, 1));
        bwrite(60, cfgw(0, 0, 0, 0, 15, 0));
        idle(2);
        bwrite(28, cfgw(0, 0, 0, 0, 0, 1));
        bwrite(60, cfgw(0, 0, 0, 0, 0, 0));
        idle(2);

        cur_req = "R11";
        bwrite(0, cfgw(0, 0, 0, 0, 15, 1));
        bwrite(16'h40, 32'h0000_FFFF);
        idle(1);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        bread(0);
        bread(16'h40);
        idle(2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule